// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit performs one of four single-bit operations on an operand: it can inspect a bit, force it high, force it low or invert it. The bit is chosen either by an immediate field or by the contents of a register. The operand is either a full register word or a single byte fetched from memory, and the operand kind sets the range that the bit number wraps into. The unit registers its result and returns the possibly modified operand, a condition-flag vector and a write-enable.

The zero flag always describes the chosen bit as it was before any change, for all four operations. The other flags are copied through untouched. The write-enable tells the surrounding datapath whether the operand must be written back. Fetching and storing memory bytes, address generation and instruction decode are done outside this unit. Each accepted request produces its result exactly one clock later.

Top module: `bitop_unit`

## Requirements
- R1: While `rst_n` is low and on the first edge after it, `out_valid`, `out_wr`, `out_operand` and `out_flags` are all zero.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low after a cycle with `in_valid` low. When `in_valid` is low, `out_operand` and `out_flags` keep their previous values.
- R3: The test operation (`in_op` = 2'b00) returns the operand unchanged.
- R4: The set operation (`in_op` = 2'b11) returns the operand with the selected bit forced to 1 and every other bit unchanged.
- R5: The clear operation (`in_op` = 2'b10) returns the operand with the selected bit forced to 0 and every other bit unchanged.
- R6: The change operation (`in_op` = 2'b01) returns the operand with only the selected bit inverted.
- R7: The zero flag is `out_flags[2]`. For every operation it is 1 when the selected bit was 0 in the incoming operand and 0 when that bit was 1.
- R8: The flags at positions 4 (extend), 3 (negative), 1 (overflow) and 0 (carry) of `out_flags` equal the same positions of `in_flags`.
- R9: With `in_byte_mode` = 0 (register operand), the bit number is the selected source value modulo 32. For example, an immediate of 37 selects bit 5.
- R10: With `in_byte_mode` = 1 (memory byte in `in_operand[7:0]`), the bit number is the source value modulo 8. Bits 31:8 pass through unchanged.
- R11: With `in_src_reg` = 0 the bit number comes from `in_imm`. With `in_src_reg` = 1 it comes from `in_reg_idx`, and the unselected source has no effect.
- R12: `out_wr` is 1 one cycle after an accepted set, clear or change operation. It is 0 after a test operation and after idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 2 | 00 test, 01 change, 10 clear, 11 set |
| in_src_reg | input | 1 | 1: bit number from `in_reg_idx`, 0: from `in_imm` |
| in_imm | input | 8 | Immediate bit number |
| in_reg_idx | input | 32 | Register value holding a bit number |
| in_byte_mode | input | 1 | 1: byte operand, 0: register operand |
| in_operand | input | 32 | Operand value (byte in bits 7:0 when in byte mode) |
| in_flags | input | 5 | Incoming flags {X, N, Z, V, C} |
| out_valid | output | 1 | Result present |
| out_operand | output | 32 | Operand after the operation |
| out_flags | output | 5 | Flags after the operation |
| out_wr | output | 1 | Operand must be written back |

## Verification
The bench builds the unit with its default parameters: a 32-bit register word, 8-bit memory bytes and an 8-bit immediate field. With these values, immediates above 31 can be driven, so wrapping is exercised in both the 32-wide and the 8-wide range. Register sources with high bits set also become reachable, which checks that only the low bits pick the position. Directed cases, followed by a long random stream with idle gaps, are compared every cycle against a behavioural model.

// File: rtl/bitop_pkg.sv
// Package: shared operation codes and flag positions for the bit test/modify unit.
// Assumes the flag vector is ordered {X, N, Z, V, C} from bit 4 down to bit 0.
package bitop_pkg;
    typedef enum logic [1:0] {
        BOP_TEST  = 2'b00,
        BOP_FLIP  = 2'b01,
        BOP_CLEAR = 2'b10,
        BOP_SET   = 2'b11
    } bop_e;

    localparam int FLAG_W = 5;
    localparam int FLG_C  = 0;
    localparam int FLG_V  = 1;
    localparam int FLG_Z  = 2;
    localparam int FLG_N  = 3;
    localparam int FLG_X  = 4;
endpackage

// File: rtl/bitop_index.sv
// Module: picks the bit-number source and wraps it to the operand width.
// Assumes REG_W and BYTE_W are powers of two, so wrapping keeps the low bits.
module bitop_index #(
    parameter int REG_W  = 32,
    parameter int BYTE_W = 8,
    parameter int IMM_W  = 8,
    localparam int IDX_W  = $clog2(REG_W),
    localparam int BIDX_W = $clog2(BYTE_W)
) (
    input  logic             src_reg,
    input  logic [IMM_W-1:0] imm,
    input  logic [REG_W-1:0] reg_idx,
    input  logic             byte_mode,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] imm_low;
    logic [IDX_W-1:0] raw;

    // Fit the immediate field to the index width.
    generate
        if (IMM_W >= IDX_W) begin : g_imm_trunc
            assign imm_low = imm[IDX_W-1:0];
        end else begin : g_imm_ext
            assign imm_low = {{(IDX_W-IMM_W){1'b0}}, imm};
        end
    endgenerate

    // Select the source and wrap it modulo the operand width.
    always_comb begin
        raw = src_reg ? reg_idx[IDX_W-1:0] : imm_low;
        if (byte_mode) begin
            idx = {{(IDX_W-BIDX_W){1'b0}}, raw[BIDX_W-1:0]};
        end else begin
            idx = raw;
        end
    end
endmodule

// File: rtl/bitop_mask.sv
// Module: decodes a bit number into a one-hot mask of width W.
// Assumes idx is always below W, which the index stage ensures.
module bitop_mask #(
    parameter int W = 32,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [W-1:0]     mask
);
    // One comparator per bit position.
    generate
        for (genvar g = 0; g < W; g++) begin : g_dec
            assign mask[g] = (idx == IDX_W'(g));
        end
    endgenerate
endmodule

// File: rtl/bitop_apply.sv
// Module: applies test, set, clear or change to the masked bit and reports
// the original value of that bit.
// Assumes mask is one-hot.
module bitop_apply
    import bitop_pkg::*;
#(
    parameter int W = 32
) (
    input  bop_e         op,
    input  logic [W-1:0] operand,
    input  logic [W-1:0] mask,
    output logic [W-1:0] result,
    output logic         orig_bit,
    output logic         modifies
);
    // Combine the operand with the mask according to the operation.
    always_comb begin
        orig_bit = |(operand & mask);
        modifies = (op != BOP_TEST);
        unique case (op)
            BOP_SET:   result = operand | mask;
            BOP_CLEAR: result = operand & ~mask;
            BOP_FLIP:  result = operand ^ mask;
            default:   result = operand;
        endcase
    end
endmodule

// File: rtl/bitop_unit.sv
// Module: top of the single-bit test/modify unit, with a one-cycle registered result.
// Assumes the caller places memory bytes in the low bits of in_operand.
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int BYTE_W = 8,
    parameter int IMM_W  = 8,
    localparam int IDX_W = $clog2(REG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic              in_src_reg,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic [REG_W-1:0]  in_reg_idx,
    input  logic              in_byte_mode,
    input  logic [REG_W-1:0]  in_operand,
    input  logic [FLAG_W-1:0] in_flags,
    output logic              out_valid,
    output logic [REG_W-1:0]  out_operand,
    output logic [FLAG_W-1:0] out_flags,
    output logic              out_wr
);
    logic [IDX_W-1:0]  idx;
    logic [REG_W-1:0]  mask;
    logic [REG_W-1:0]  result;
    logic              orig_bit;
    logic              modifies;
    logic [FLAG_W-1:0] flags_nxt;

    bitop_index #(.REG_W(REG_W), .BYTE_W(BYTE_W), .IMM_W(IMM_W)) u_index (
        .src_reg   (in_src_reg),
        .imm       (in_imm),
        .reg_idx   (in_reg_idx),
        .byte_mode (in_byte_mode),
        .idx       (idx)
    );

    bitop_mask #(.W(REG_W)) u_mask (
        .idx  (idx),
        .mask (mask)
    );

    bitop_apply #(.W(REG_W)) u_apply (
        .op       (bop_e'(in_op)),
        .operand  (in_operand),
        .mask     (mask),
        .result   (result),
        .orig_bit (orig_bit),
        .modifies (modifies)
    );

    // Replace only the zero flag; the others pass through.
    always_comb begin
        flags_nxt        = in_flags;
        flags_nxt[FLG_Z] = ~orig_bit;
    end

    // Register the result; hold the data while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_operand <= '0;
            out_flags   <= '0;
            out_wr      <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_wr    <= in_valid & modifies;
            if (in_valid) begin
                out_operand <= result;
                out_flags   <= flags_nxt;
            end
        end
    end
endmodule

// File: rtl/bitop_unit_chk.sv
// Module: property checker for bitop_unit, attached with bind.
// Assumes the stimulus keeps in_valid low while reset is asserted.
module bitop_unit_chk #(
    parameter int REG_W  = 32,
    parameter int IMM_W  = 8,
    localparam int IDX_W = $clog2(REG_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       in_op,
    input logic             in_src_reg,
    input logic [IMM_W-1:0] in_imm,
    input logic [REG_W-1:0] in_reg_idx,
    input logic             in_byte_mode,
    input logic [REG_W-1:0] in_operand,
    input logic [4:0]       in_flags,
    input logic             out_valid,
    input logic [REG_W-1:0] out_operand,
    input logic [4:0]       out_flags,
    input logic             out_wr
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_operand) && $stable(out_flags)));
    // R3
    test_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b00) |=> (out_operand == $past(in_operand) && !out_wr));
    // R4
    set_only_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b11) |=>
            (((~out_operand & $past(in_operand)) == '0) &&
             ($countones(out_operand & ~$past(in_operand)) <= 1)));
    // R5
    clear_only_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b10) |=>
            (((out_operand & ~$past(in_operand)) == '0) &&
             ($countones(~out_operand & $past(in_operand)) <= 1)));
    // R6
    flip_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b01) |=> ($countones(out_operand ^ $past(in_operand)) == 1));
    // R7
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_src_reg && !in_byte_mode) |=>
            (out_flags[2] == !$past(in_operand[in_reg_idx[IDX_W-1:0]])));
    // R8
    flags_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (((out_flags ^ $past(in_flags)) & 5'b11011) == 5'b00000));
    // R10
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_byte_mode) |=> (out_operand[REG_W-1:8] == $past(in_operand[REG_W-1:8])));
    // R12
    wr_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op != 2'b00) |=> out_wr);
    // R12
    wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_wr);
endmodule

bind bitop_unit bitop_unit_chk #(.REG_W(REG_W), .IMM_W(IMM_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_op        (in_op),
    .in_src_reg   (in_src_reg),
    .in_imm       (in_imm),
    .in_reg_idx   (in_reg_idx),
    .in_byte_mode (in_byte_mode),
    .in_operand   (in_operand),
    .in_flags     (in_flags),
    .out_valid    (out_valid),
    .out_operand  (out_operand),
    .out_flags    (out_flags),
    .out_wr       (out_wr)
);

// File: tb/bitop_unit_test.sv
`timescale 1ns/1ps
module bitop_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic        in_src_reg = 1'b0;
    logic [7:0]  in_imm = '0;
    logic [31:0] in_reg_idx = '0;
    logic        in_byte_mode = 1'b0;
    logic [31:0] in_operand = '0;
    logic [4:0]  in_flags = '0;
    logic        out_valid;
    logic [31:0] out_operand;
    logic [4:0]  out_flags;
    logic        out_wr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic        m_valid = 1'b0;
    logic        m_wr = 1'b0;
    logic [31:0] m_data = '0;
    logic [4:0]  m_flags = '0;

    always #4 clk = ~clk;

    bitop_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_src_reg(in_src_reg), .in_imm(in_imm), .in_reg_idx(in_reg_idx),
        .in_byte_mode(in_byte_mode), .in_operand(in_operand), .in_flags(in_flags),
        .out_valid(out_valid), .out_operand(out_operand), .out_flags(out_flags),
        .out_wr(out_wr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'b00: return "R3";
            2'b01: return "R6";
            2'b10: return "R5";
            default: return "R4";
        endcase
    endfunction

    // Drive one cycle at a falling edge, predict, then compare at the next falling edge.
    task automatic step(input logic v, input logic [1:0] op, input logic sr, input logic [7:0] imm,
                        input logic [31:0] ri, input logic bm, input logic [31:0] opd,
                        input logic [4:0] fl);
        int unsigned sel;
        int unsigned pos;
        logic orig;
        in_valid = v; in_op = op; in_src_reg = sr; in_imm = imm;
        in_reg_idx = ri; in_byte_mode = bm; in_operand = opd; in_flags = fl;
        sel = sr ? ri : {24'd0, imm};
        pos = sel % (bm ? 8 : 32);
        orig = opd[pos];
        m_valid = v;
        m_wr = v && (op != 2'b00);
        if (v) begin
            m_data = opd;
            case (op)
                2'b01: m_data[pos] = ~orig;
                2'b10: m_data[pos] = 1'b0;
                2'b11: m_data[pos] = 1'b1;
                default: ;
            endcase
            m_flags = fl;
            m_flags[2] = ~orig;
        end
        @(negedge clk);
        chk("R2 valid", {31'd0, out_valid}, {31'd0, m_valid});
        chk("R12 wr", {31'd0, out_wr}, {31'd0, m_wr});
        if (v) begin
            chk({op_tag(op), " data"}, out_operand, m_data);
            chk(bm ? "R10 index" : (sr ? "R9/R11 index" : "R9 index"), out_operand, m_data);
            chk("R7 zero", {31'd0, out_flags[2]}, {31'd0, m_flags[2]});
            chk("R8 flags", {27'd0, out_flags & 5'b11011}, {27'd0, m_flags & 5'b11011});
        end else begin
            chk("R2 hold data", out_operand, m_data);
            chk("R2 hold flags", {27'd0, out_flags}, {27'd0, m_flags});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs zero during reset
        chk("R1 valid", {31'd0, out_valid}, 32'd0);
        chk("R1 wr", {31'd0, out_wr}, 32'd0);
        chk("R1 data", out_operand, 32'd0);
        chk("R1 flags", {27'd0, out_flags}, 32'd0);
        rst_n = 1'b1;
        // R9: immediate 37 on a register operand selects bit 5
        step(1, 2'b11, 0, 8'd37, 32'd0, 0, 32'h0000_0000, 5'b11011);
        chk("R9 imm37", out_operand, 32'h0000_0020);
        // R10: immediate 13 on a byte clears bit 5, upper bits kept
        step(1, 2'b10, 0, 8'd13, 32'd0, 1, 32'hABCD_00FF, 5'b00000);
        chk("R10 byte", out_operand, 32'hABCD_00DF);
        // R11: register source used, immediate ignored
        step(1, 2'b01, 1, 8'd0, 32'hFFFF_FFE7, 0, 32'h0000_0001, 5'b10001);
        chk("R11 regsrc", out_operand, 32'h0000_0081);
        // R11: immediate used, register value ignored
        step(1, 2'b01, 0, 8'd1, 32'd4, 0, 32'h0000_0000, 5'b00000);
        chk("R11 immsrc", out_operand, 32'h0000_0002);
        // R7: test of a set bit clears Z, test of a clear bit sets Z
        step(1, 2'b00, 0, 8'd31, 32'd0, 0, 32'h8000_0000, 5'b00100);
        chk("R7 bit1", {31'd0, out_flags[2]}, 32'd0);
        step(1, 2'b00, 0, 8'd30, 32'd0, 0, 32'h8000_0000, 5'b00000);
        chk("R7 bit0", {31'd0, out_flags[2]}, 32'd1);
        // R7: set reports the original 0 bit
        step(1, 2'b11, 0, 8'd3, 32'd0, 1, 32'h0000_0000, 5'b00000);
        chk("R7 set orig", {31'd0, out_flags[2]}, 32'd1);
        step(0, 2'b11, 0, 8'd0, 32'd0, 0, 32'hFFFF_FFFF, 5'b11111);
        for (int i = 0; i < 600; i++) begin
            logic v;
            v = ($urandom_range(0, 4) != 0);
            step(v, 2'($urandom), 1'($urandom), 8'($urandom), $urandom, 1'($urandom),
                 $urandom, 5'($urandom));
        end
        step(0, 2'b00, 0, 8'd0, 32'd0, 0, 32'd0, 5'd0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule